// File: doc/BRIEF.md
# Transfer Activation Enable Register Bank

This block holds the per-source enables that decide which interrupt request lines start a data-transfer request instead of interrupting the CPU. It has a parameterised number of registers (eight by default), each 16 bits wide, which gives one enable bit per request line (128 by default). Each request line is ANDed with its enable bit. The result is a request vector that goes straight to the transfer engine, with no register in the path.

The CPU reaches the bank through a simple register port. One cycle of `cpu_sel` is one access. Reads return the whole addressed register. Writes use two byte-lane enables. Each cycle is decoded into one of three access kinds: ACC_IDLE (no access), ACC_READ or ACC_WRITE. There is no state machine beyond this per-cycle decode.

Software cannot clear a bit by accident:

- Every bit has a read-as-one flag. A read that returns 1 for a bit sets that bit's flag.
- The next write to that register's lane consumes the flags of that lane.
- Writing 0 clears a bit only if its flag was set.

Software can therefore do a dummy read followed by one write to change several bits at once. The transfer engine sends completion pulses back. Each pulse carries a source index, a mode flag (interrupt on every transfer) and a count-ended flag. Hardware clears the enable bit when either flag is set. A software set to the same bit in the same cycle takes priority over that clear.

Top module: `act_enable_bank`

## Requirements
- R1: After reset every enable bit reads 0 and every bit of `act_req` is 0.
- R2: `act_req[i]` equals `irq_line[i] & enable[i]`, where enable bit i is bit i%16 of register i/16. The output is combinational, with no cycle of delay.
- R3: A write places a 1 in every bit where `cpu_wdata` is 1 and the byte lane is enabled (`cpu_be[0]` covers bits 7:0, `cpu_be[1]` covers bits 15:8). This does not depend on any earlier read.
- R4: Writing 0 to a bit that was not read as 1 since the last write to its lane leaves the bit unchanged.
- R5: Writing 0 to a bit that an earlier read of the same register returned as 1 clears it. The write consumes the read-as-one flags of its lanes, so a second write of 0 without a new read has no effect.
- R6: A completion pulse (`done_valid`) with `done_every`=1 clears enable bit `done_idx` on the next clock edge.
- R7: A completion pulse with `done_cnt_end`=1 clears enable bit `done_idx` on the next clock edge.
- R8: A completion pulse with `done_every`=0 and `done_cnt_end`=0 leaves the enable bit unchanged.
- R9: If a software write sets the same bit that a completion pulse clears in the same cycle, the bit ends up 1.
- R10: A byte write changes only its own lane. The other lane's bits and read-as-one flags stay untouched.
- R11: One dummy read followed by one word write can set some bits and clear others in the same register at once.
- R12: A read (`cpu_sel`=1, `cpu_wr`=0) returns the addressed register on `cpu_rdata` in the same cycle and changes no enable bit. When no read is in progress, `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Register access this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register index |
| cpu_be | input | 2 | Byte-lane enables for writes and for setting read-as-one flags |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data (combinational) |
| irq_line | input | 128 | Interrupt request lines |
| act_req | output | 128 | Gated transfer-activation requests |
| done_valid | input | 1 | Transfer-completion pulse |
| done_idx | input | 7 | Source index of the completed transfer |
| done_every | input | 1 | Interrupt-on-every-transfer mode flag |
| done_cnt_end | input | 1 | Programmed transfer count has run out |

## Verification
A wrong enable bit shows up on `act_req` in the same cycle, as soon as its request line is driven high. It also shows up on `cpu_rdata` at the next read of its register. A wrong read-as-one flag cannot be seen directly: it only appears when a later write of 0 clears a bit it should have kept, or keeps a bit it should have cleared. The bench therefore always reads back after such writes. Hardware clears take effect one edge after the pulse, so the bench reads them back in the following access.

// File: rtl/act_en_pkg.sv
package act_en_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;
endpackage

// File: rtl/act_en_decode.sv
module act_en_decode
    import act_en_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 16,
    localparam int SRC_W   = NUM_REGS * REG_W,
    localparam int ADDR_W  = $clog2(NUM_REGS),
    localparam int IDX_W   = $clog2(SRC_W)
) (
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              done_valid,
    input  logic [IDX_W-1:0]  done_idx,
    input  logic              done_every,
    input  logic              done_cnt_end,
    output acc_e              op,
    output logic [NUM_REGS-1:0] hit,
    output logic [SRC_W-1:0]  hw_clr
);
    always_comb begin
        if (!cpu_sel)    op = ACC_IDLE;
        else if (cpu_wr) op = ACC_WRITE;
        else             op = ACC_READ;
    end

    logic clr_ev;
    assign clr_ev = done_valid && (done_every || done_cnt_end);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
        assign hit[r] = cpu_sel && (cpu_addr == ADDR_W'(r));
    end

    for (genvar i = 0; i < SRC_W; i++) begin : g_clr
        assign hw_clr[i] = clr_ev && (done_idx == IDX_W'(i));
    end
endmodule

// File: rtl/act_en_reg.sv
module act_en_reg
    import act_en_pkg::*;
#(
    parameter int REG_W   = 16,
    localparam int LANES  = REG_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_e             op,
    input  logic             hit,
    input  logic [LANES-1:0] be,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] hw_clr,
    output logic [REG_W-1:0] en
);
    logic [REG_W-1:0] en_q, en_d;
    logic [REG_W-1:0] flag_q, flag_d;
    logic [REG_W-1:0] lane_m;
    logic [REG_W-1:0] sw_set;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_m[l*8 +: 8] = {8{be[l]}};
    end

    always_comb begin
        en_d   = en_q;
        flag_d = flag_q;
        sw_set = '0;
        unique case (op)
            ACC_READ: begin
                if (hit) flag_d = flag_q | (en_q & lane_m);
            end
            ACC_WRITE: begin
                if (hit) begin
                    sw_set = wdata & lane_m;
                    en_d   = (en_q & ~lane_m)
                           | (lane_m & (wdata | (en_q & ~flag_q)));
                    flag_d = flag_q & ~lane_m;
                end
            end
            default: ;
        endcase
        en_d = (en_d & ~hw_clr) | sw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            flag_q <= '0;
        end else begin
            en_q   <= en_d;
            flag_q <= flag_d;
        end
    end

    assign en = en_q;
endmodule

// File: rtl/act_enable_bank.sv
module act_enable_bank
    import act_en_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 16,
    localparam int SRC_W   = NUM_REGS * REG_W,
    localparam int ADDR_W  = $clog2(NUM_REGS),
    localparam int IDX_W   = $clog2(SRC_W),
    localparam int LANES   = REG_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [LANES-1:0]  cpu_be,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    input  logic [SRC_W-1:0]  irq_line,
    output logic [SRC_W-1:0]  act_req,
    input  logic              done_valid,
    input  logic [IDX_W-1:0]  done_idx,
    input  logic              done_every,
    input  logic              done_cnt_end
);
    acc_e                op;
    logic [NUM_REGS-1:0] hit;
    logic [SRC_W-1:0]    hw_clr;
    logic [SRC_W-1:0]    en_flat;
    logic [REG_W-1:0]    en_arr [NUM_REGS];

    act_en_decode #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_dec (
        .cpu_sel      (cpu_sel),
        .cpu_wr       (cpu_wr),
        .cpu_addr     (cpu_addr),
        .done_valid   (done_valid),
        .done_idx     (done_idx),
        .done_every   (done_every),
        .done_cnt_end (done_cnt_end),
        .op           (op),
        .hit          (hit),
        .hw_clr       (hw_clr)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        act_en_reg #(.REG_W(REG_W)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .op     (op),
            .hit    (hit[r]),
            .be     (cpu_be),
            .wdata  (cpu_wdata),
            .hw_clr (hw_clr[r*REG_W +: REG_W]),
            .en     (en_arr[r])
        );
        assign en_flat[r*REG_W +: REG_W] = en_arr[r];
    end

    assign cpu_rdata = (op == ACC_READ) ? en_arr[cpu_addr] : '0;
    assign act_req   = irq_line & en_flat;
endmodule

// File: rtl/act_enable_bank_chk.sv
module act_enable_bank_chk #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 16,
    localparam int SRC_W   = NUM_REGS * REG_W,
    localparam int ADDR_W  = $clog2(NUM_REGS),
    localparam int IDX_W   = $clog2(SRC_W),
    localparam int LOG_W   = $clog2(REG_W),
    localparam int LANES   = REG_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_sel,
    input logic              cpu_wr,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [LANES-1:0]  cpu_be,
    input logic [REG_W-1:0]  cpu_wdata,
    input logic [SRC_W-1:0]  irq_line,
    input logic [SRC_W-1:0]  act_req,
    input logic              done_valid,
    input logic [IDX_W-1:0]  done_idx,
    input logic              done_every,
    input logic              done_cnt_end,
    input logic [SRC_W-1:0]  en_flat
);
    logic [LOG_W-1:0] bit_pos;
    logic             sw_hits_idx;
    assign bit_pos     = done_idx[LOG_W-1:0];
    assign sw_hits_idx = cpu_sel && cpu_wr
                      && (done_idx[IDX_W-1:LOG_W] == cpu_addr)
                      && cpu_wdata[bit_pos] && cpu_be[bit_pos >> 3];

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_req & ~irq_line) == '0) && ((act_req & ~en_flat) == '0)); // R2

    AST_SET_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_sel && cpu_wr) |=> ((en_flat & ~$past(en_flat)) == '0)); // R3

    AST_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && (done_every || done_cnt_end) && !(cpu_sel && cpu_wr))
        |=> !en_flat[$past(done_idx)]); // R6

    AST_HW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_every && !done_cnt_end && en_flat[done_idx]
         && !(cpu_sel && cpu_wr))
        |=> en_flat[$past(done_idx)]); // R8

    AST_SW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && sw_hits_idx) |=> en_flat[$past(done_idx)]); // R9

    AST_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cpu_sel && cpu_wr) && !done_valid) |=> $stable(en_flat)); // R12
endmodule

bind act_enable_bank act_enable_bank_chk #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_sel      (cpu_sel),
    .cpu_wr       (cpu_wr),
    .cpu_addr     (cpu_addr),
    .cpu_be       (cpu_be),
    .cpu_wdata    (cpu_wdata),
    .irq_line     (irq_line),
    .act_req      (act_req),
    .done_valid   (done_valid),
    .done_idx     (done_idx),
    .done_every   (done_every),
    .done_cnt_end (done_cnt_end),
    .en_flat      (en_flat)
);

// File: tb/act_enable_bank_bench.sv
module act_enable_bank_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_sel = 1'b0, cpu_wr = 1'b0;
    logic [2:0]   cpu_addr = '0;
    logic [1:0]   cpu_be = '0;
    logic [15:0]  cpu_wdata = '0;
    logic [15:0]  cpu_rdata;
    logic [127:0] irq_line = '0;
    logic [127:0] act_req;
    logic         done_valid = 1'b0;
    logic [6:0]   done_idx = '0;
    logic         done_every = 1'b0, done_cnt_end = 1'b0;

    int checks = 0;
    int failures = 0;
    logic [127:0] m_en = '0;
    logic [127:0] m_flag = '0;

    always #4 clk = ~clk;

    act_enable_bank u_act_enable_bank (
        .clk(clk), .rst_n(rst_n),
        .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_be(cpu_be), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq_line(irq_line), .act_req(act_req),
        .done_valid(done_valid), .done_idx(done_idx),
        .done_every(done_every), .done_cnt_end(done_cnt_end)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lmask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    // One bus cycle: optional access plus optional completion pulse.
    task automatic cyc(input string req, input bit sel, input bit wr, input int a,
                       input logic [1:0] be, input logic [15:0] wd,
                       input bit dv, input int idx, input bit ev, input bit ce);
        logic [15:0] cur, fl, m, nxt, setb;
        @(negedge clk);
        cpu_sel = sel; cpu_wr = wr; cpu_addr = 3'(a); cpu_be = be; cpu_wdata = wd;
        done_valid = dv; done_idx = 7'(idx); done_every = ev; done_cnt_end = ce;
        #1;
        if (sel && !wr) check(req, {112'd0, cpu_rdata}, {112'd0, m_en[a*16 +: 16]});
        cur = m_en[a*16 +: 16]; fl = m_flag[a*16 +: 16]; m = lmask(be);
        setb = '0;
        if (sel && !wr) m_flag[a*16 +: 16] = fl | (cur & m);
        if (sel && wr) begin
            setb = wd & m;
            nxt  = cur;
            for (int b = 0; b < 16; b++)
                if (m[b]) nxt[b] = wd[b] ? 1'b1 : (fl[b] ? 1'b0 : cur[b]);
            m_en[a*16 +: 16]   = nxt;
            m_flag[a*16 +: 16] = fl & ~m;
        end
        if (dv && (ev || ce)) begin
            if (!(sel && wr && (idx / 16 == a) && setb[idx % 16])) m_en[idx] = 1'b0;
        end
        @(posedge clk);
        #1;
        cpu_sel = 0; cpu_wr = 0; done_valid = 0;
    endtask

    task automatic rd(input string req, input int a, input logic [1:0] be);
        cyc(req, 1, 0, a, be, 16'h0, 0, 0, 0, 0);
    endtask

    task automatic wr(input string req, input int a, input logic [1:0] be, input logic [15:0] d);
        cyc(req, 1, 1, a, be, d, 0, 0, 0, 0);
    endtask

    task automatic chk_req(input string req, input logic [127:0] irq);
        @(negedge clk);
        irq_line = irq;
        #1;
        check(req, act_req, irq & m_en);
    endtask

    task automatic rd_all(input string req);
        for (int r = 0; r < 8; r++) rd(req, r, 2'b11);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd_all("R1");
        chk_req("R1", {128{1'b1}});

        // R3 / R12: word write sweep, readback of every register
        for (int r = 0; r < 8; r++) wr("R3", r, 2'b11, 16'hA5C3 ^ 16'(r * 16'h1111));
        rd_all("R12");

        // R2: gating sweep
        chk_req("R2", {128{1'b1}});
        chk_req("R2", {4{32'hDEAD_BEEF}});
        chk_req("R2", {64{2'b01}});
        chk_req("R2", 128'd0);
        for (int i = 0; i < 128; i += 9) chk_req("R2", 128'd1 << i);

        // R3 then R4: set all, then write 0 without a prior read
        for (int r = 0; r < 8; r++) wr("R3", r, 2'b11, 16'hFFFF);
        for (int r = 0; r < 8; r++) wr("R4", r, 2'b11, 16'h0000);
        rd_all("R4");

        // R5: read-as-one then write 0 clears; flag consumed by next write
        rd("R5", 1, 2'b11);
        wr("R5", 1, 2'b11, 16'h0000);
        rd("R5", 1, 2'b11);
        rd("R5", 3, 2'b11);
        wr("R5", 3, 2'b11, 16'hFFFF);
        wr("R5", 3, 2'b11, 16'h0000);
        rd("R5", 3, 2'b11);

        // R10: byte lanes keep their own data and flags
        rd("R10", 2, 2'b01);
        wr("R10", 2, 2'b10, 16'h0000);
        wr("R10", 2, 2'b01, 16'h0000);
        rd("R10", 2, 2'b11);
        wr("R10", 4, 2'b11, 16'hFFFF);
        rd("R10", 4, 2'b11);
        wr("R10", 4, 2'b01, 16'h0000);
        wr("R10", 4, 2'b10, 16'h0000);
        rd("R10", 4, 2'b11);

        // R11: dummy read then a single multi-bit write
        wr("R11", 5, 2'b11, 16'hF0F0);
        rd("R11", 5, 2'b11);
        wr("R11", 5, 2'b11, 16'h0F3C);
        rd("R11", 5, 2'b11);

        // R6 / R7 / R8: completion sweep over every source
        for (int r = 0; r < 8; r++) wr("R6", r, 2'b11, 16'hFFFF);
        for (int i = 0; i < 128; i++)
            cyc((i % 3 == 0) ? "R6" : (i % 3 == 1) ? "R7" : "R8",
                0, 0, 0, 2'b00, 16'h0, 1, i, (i % 3 == 0), (i % 3 == 1));
        rd_all("R6");
        chk_req("R8", {128{1'b1}});

        // R9: software set beats same-cycle hardware clear
        wr("R9", 6, 2'b11, 16'hFFFF);
        cyc("R9", 1, 1, 6, 2'b01, 16'h0010, 1, 6 * 16 + 4, 1, 0);
        cyc("R9", 1, 1, 6, 2'b10, 16'h0200, 1, 6 * 16 + 9, 0, 1);
        cyc("R9", 1, 1, 6, 2'b01, 16'h0000, 1, 6 * 16 + 5, 1, 1);
        rd("R9", 6, 2'b11);
        chk_req("R9", {128{1'b1}});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule